// File: doc/BRIEF.md
# Width-Scalable Link Packet Serializer

This block sits between a packet buffer and the transmit side of a point-to-point command/address/data lane bus. The buffer hands it one 32-bit dword at a time over a ready/valid handshake, together with a flag saying whether the dword belongs to a control packet or a data packet. The serializer spreads the dword over one or more output beats. One beat is one bit time of the link. How many lanes carry payload in a beat is set at run time to 2, 4, 8, 16 or 32 bits.

The byte-to-lane mapping follows from a single rule: beat k places dword bits [k*W +: W] on the low W lanes. For links of 8 bits or fewer, this sends the bytes in order, least significant byte first, and the low bits of each byte go out first. On a 16-bit link the even-numbered byte goes on lanes 7:0 and the odd-numbered byte on lanes 15:8. On a 32-bit link the whole dword goes out in one beat. The control flag stays constant for every beat of a dword, so it can change only on a dword boundary. When nothing is queued, the lanes are zero and the flag is high, so an idle link looks like null control traffic.

The width setting is sampled only at the moment a dword is accepted. A change made while a dword is partly sent therefore has no effect until the next dword.

Top module: `link_serializer`

## Requirements
- R1: While reset is high and in the first cycle after it, lane_out is 0, lane_ctl is 1 and src_ready is 1.
- R2: In every beat where no dword is being sent, lane_out is all zeros, lane_ctl is 1 and src_ready is 1.
- R3: The width code cfg_width selects the link width W as follows: 0 selects 2 bits, 1 selects 4, 2 selects 8, 3 selects 16 and 4 selects 32; codes 5 to 7 select 8 bits. A dword occupies 32/W consecutive beats, starting the cycle after it is accepted. src_ready is low in every one of those beats except the last.
- R4: Beat k of a dword, counting from 0, drives dword bits [k*W +: W] on lane_out[W-1:0], and lane_out bits above W-1 are 0. At W=16 this places byte 0 on lanes 7:0 and byte 1 on lanes 15:8. At W=2 byte 0 is sent as bits 1:0, then 3:2, then 5:4, then 7:6.
- R5: lane_ctl equals the src_is_ctl value captured with the dword, in every beat of that dword. The value is 1 for control and 0 for data.
- R6: The width used for a dword is the cfg_width value at its accepting edge. Changing cfg_width while the dword is being sent does not alter its remaining beats.
- R7: A dword is accepted on a clock edge where src_valid and src_ready are both 1. When a dword is accepted in the last beat of the previous one, its first beat follows with no idle beat in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one beat per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 3 | Requested link width code (see R3) |
| src_data | input | 32 | Dword offered by the source |
| src_is_ctl | input | 1 | 1 = control packet dword, 0 = data packet dword |
| src_valid | input | 1 | Source offers a dword |
| src_ready | output | 1 | Serializer takes a dword at the next edge if src_valid is high |
| lane_out | output | 32 | Lane bus for the current beat |
| lane_ctl | output | 1 | Control/data flag for the current beat |

## Verification
The same dword, 0x44332211, is sent at every width code. Its distinct bytes show whether a failure is a byte-order swap, a lane swap at 16 bits or a wrong in-byte bit order below 8 bits. Data dwords with alternating patterns are mixed with control dwords to check that the flag follows the dword and not the beat. One test sends an out-of-range width code to exercise the fallback to 8 bits. Another rewrites cfg_width in the middle of a 2-bit dword to show that only the next dword sees the change. Dwords are sent both back to back and with idle gaps, which separates accept-on-last-beat timing from the idle pattern.

// File: rtl/link_ser_pkg.sv
package link_ser_pkg;

    localparam int DWORD_BITS = 32;
    localparam int MIN_WIDTH  = 2;
    localparam int MAX_BEATS  = DWORD_BITS / MIN_WIDTH;
    localparam int CNT_W      = $clog2(MAX_BEATS);

    typedef enum logic [2:0] {
        WID_2  = 3'd0,
        WID_4  = 3'd1,
        WID_8  = 3'd2,
        WID_16 = 3'd3,
        WID_32 = 3'd4
    } width_code_e;

    typedef struct packed {
        logic [DWORD_BITS-1:0] bits;
        logic                  is_ctl;
    } dword_t;

    // Codes outside the defined set fall back to the 8-bit width.
    function automatic logic [CNT_W-1:0] last_beat_idx(input logic [2:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            WID_2:   r = CNT_W'(DWORD_BITS / 2  - 1);
            WID_4:   r = CNT_W'(DWORD_BITS / 4  - 1);
            WID_16:  r = CNT_W'(DWORD_BITS / 16 - 1);
            WID_32:  r = CNT_W'(DWORD_BITS / 32 - 1);
            default: r = CNT_W'(DWORD_BITS / 8  - 1);
        endcase
        return r;
    endfunction

    function automatic logic [DWORD_BITS-1:0] lane_mask(input logic [2:0] code);
        logic [DWORD_BITS-1:0] m;
        case (code)
            WID_2:   m = DWORD_BITS'(32'h0000_0003);
            WID_4:   m = DWORD_BITS'(32'h0000_000F);
            WID_16:  m = DWORD_BITS'(32'h0000_FFFF);
            WID_32:  m = '1;
            default: m = DWORD_BITS'(32'h0000_00FF);
        endcase
        return m;
    endfunction

    function automatic logic [DWORD_BITS-1:0] advance(input logic [DWORD_BITS-1:0] v,
                                                      input logic [2:0] code);
        logic [DWORD_BITS-1:0] r;
        case (code)
            WID_2:   r = v >> 2;
            WID_4:   r = v >> 4;
            WID_16:  r = v >> 16;
            WID_32:  r = '0;
            default: r = v >> 8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsr_width_latch.sv
module lsr_width_latch
    import link_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [2:0] req_code,
    output logic [2:0] act_code
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_code <= WID_8;
        end else if (take) begin
            act_code <= req_code;
        end
    end

endmodule

// File: rtl/lsr_beat_shifter.sv
module lsr_beat_shifter
    import link_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  dword_t                in_word,
    input  logic [2:0]            load_code,
    input  logic [2:0]            run_code,
    output logic                  busy,
    output logic                  last,
    output logic [DWORD_BITS-1:0] shreg,
    output logic                  ctl
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
            ctl   <= 1'b1;
        end else if (load) begin
            busy  <= 1'b1;
            cnt   <= last_beat_idx(load_code);
            shreg <= in_word.bits;
            ctl   <= in_word.is_ctl;
        end else if (busy) begin
            shreg <= advance(shreg, run_code);
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign last = busy && (cnt == '0);

    // R3: a dword in flight keeps counting its beats down by one.
    a_r3_beat_countdown: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0 && !load) |=> (busy && cnt == $past(cnt) - 1'b1));

    // R5: the flag cannot move inside a dword.
    a_r5_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> $stable(ctl));

endmodule

// File: rtl/lsr_lane_mux.sv
module lsr_lane_mux
    import link_ser_pkg::*;
(
    input  logic                  busy,
    input  logic [DWORD_BITS-1:0] shreg,
    input  logic                  ctl,
    input  logic [2:0]            code,
    output logic [DWORD_BITS-1:0] lanes,
    output logic                  flag
);

    always_comb begin
        if (busy) begin
            lanes = shreg & lane_mask(code);
            flag  = ctl;
        end else begin
            lanes = '0;
            flag  = 1'b1;
        end
    end

endmodule

// File: rtl/link_serializer.sv
module link_serializer
    import link_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            cfg_width,
    input  logic [DWORD_BITS-1:0] src_data,
    input  logic                  src_is_ctl,
    input  logic                  src_valid,
    output logic                  src_ready,
    output logic [DWORD_BITS-1:0] lane_out,
    output logic                  lane_ctl
);

    logic                  busy;
    logic                  last;
    logic                  load;
    logic [2:0]            act_code;
    logic [DWORD_BITS-1:0] shreg;
    logic                  ctl_q;
    dword_t                in_word;

    assign src_ready = !busy || last;
    assign load      = src_valid && src_ready;
    assign in_word   = '{bits: src_data, is_ctl: src_is_ctl};

    lsr_width_latch u_width (
        .clk      (clk),
        .rst      (rst),
        .take     (load),
        .req_code (cfg_width),
        .act_code (act_code)
    );

    lsr_beat_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .in_word   (in_word),
        .load_code (cfg_width),
        .run_code  (act_code),
        .busy      (busy),
        .last      (last),
        .shreg     (shreg),
        .ctl       (ctl_q)
    );

    lsr_lane_mux u_mux (
        .busy  (busy),
        .shreg (shreg),
        .ctl   (ctl_q),
        .code  (act_code),
        .lanes (lane_out),
        .flag  (lane_ctl)
    );

    // R6: the latched width holds for the rest of a dword.
    a_r6_width_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> $stable(act_code));

    // R2: idle beats carry null control traffic.
    a_r2_idle_pattern: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lane_out == '0 && lane_ctl && src_ready));

    // R4: lanes above the active width stay quiet.
    a_r4_upper_quiet: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((lane_out & ~lane_mask(act_code)) == '0));

    // R7: a dword is taken on the edge after its last beat shows ready.
    a_r7_chain: assert property (@(posedge clk) disable iff (rst)
        (last && src_valid) |=> busy);

endmodule

// File: tb/test_link_serializer.sv
module test_link_serializer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_width = 3'd2;
    logic [31:0] src_data = '0;
    logic        src_is_ctl = 1'b0;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic [31:0] lane_out;
    logic        lane_ctl;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] lanes;
        logic        ctl;
        logic        rdy;
        string       tag;
    } beat_t;

    beat_t exp_q[$];

    always #5 clk = ~clk;

    link_serializer i_link_serializer (
        .clk        (clk),
        .rst        (rst),
        .cfg_width  (cfg_width),
        .src_data   (src_data),
        .src_is_ctl (src_is_ctl),
        .src_valid  (src_valid),
        .src_ready  (src_ready),
        .lane_out   (lane_out),
        .lane_ctl   (lane_ctl)
    );

    function automatic int wbits(input int code);
        case (code)
            0: return 2;
            1: return 4;
            3: return 16;
            4: return 32;
            default: return 8;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] al, input logic [31:0] el,
                         input logic ac, input logic ec, input logic ar, input logic er);
        checks++;
        if (al !== el || ac !== ec || ar !== er) begin
            errors++;
            $display("FAIL %s: lanes=%h ctl=%b rdy=%b expected lanes=%h ctl=%b rdy=%b",
                     tag, al, ac, ar, el, ec, er);
        end
    endtask

    // Driver: offers one dword, then pushes the expected beats after the accepting edge.
    task automatic send(input logic [31:0] d, input logic c, input int code,
                        input int mid_code, input string tag);
        int w;
        @(negedge clk);
        cfg_width  = 3'(code);
        src_data   = d;
        src_is_ctl = c;
        src_valid  = 1'b1;
        while (!src_ready) @(negedge clk);
        @(posedge clk);
        w = wbits(code);
        for (int k = 0; k < 32 / w; k++) begin
            beat_t b;
            logic [31:0] m;
            m       = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
            b.lanes = (d >> (k * w)) & m;
            b.ctl   = c;
            b.rdy   = (k == 32 / w - 1);
            b.tag   = tag;
            exp_q.push_back(b);
        end
        #1;
        src_valid = 1'b0;
        src_data  = 32'hDEAD_BEEF;
        if (mid_code >= 0) cfg_width = 3'(mid_code);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops and compares at every falling edge after reset.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (exp_q.size() != 0) begin
                    beat_t b;
                    b = exp_q.pop_front();
                    check(b.tag, lane_out, b.lanes, lane_ctl, b.ctl, src_ready, b.rdy);
                end else begin
                    check("R2 idle beat", lane_out, 32'h0, lane_ctl, 1'b1, src_ready, 1'b1);
                end
            end
        end
    end

    task automatic run();
        repeat (3) @(negedge clk);
        check("R1 during reset", lane_out, 32'h0, lane_ctl, 1'b1, src_ready, 1'b1);
        rst = 1'b0;
        idle(3);
        // R3/R4: one distinctive dword at every width
        send(32'h4433_2211, 1'b1, 2, -1, "R4 width8 byte order");
        idle(2);
        send(32'h4433_2211, 1'b1, 0, -1, "R4 width2 bit order");
        idle(2);
        send(32'h4433_2211, 1'b1, 1, -1, "R3 width4");
        idle(2);
        send(32'h4433_2211, 1'b1, 3, -1, "R4 width16 lane split");
        idle(2);
        send(32'h4433_2211, 1'b1, 4, -1, "R3 width32");
        idle(2);
        // R3: out-of-range code falls back to 8 bits
        send(32'hA5C3_0F96, 1'b0, 6, -1, "R3 code6 as width8");
        idle(2);
        // R5: data and control dwords interleaved back to back (R7)
        send(32'h1234_5678, 1'b1, 3, -1, "R5 control dword");
        send(32'hAAAA_5555, 1'b0, 3, -1, "R5 data dword");
        send(32'h0000_0000, 1'b1, 2, -1, "R7 chained zero control");
        send(32'hFFFF_FFFF, 1'b0, 4, -1, "R7 chained data w32");
        send(32'h8000_0001, 1'b0, 4, -1, "R7 chained data w32 b");
        idle(3);
        // R6: width rewritten in the middle of a 2-bit dword
        send(32'hC0FF_EE11, 1'b0, 0, 4, "R6 mid-dword width change");
        idle(20);
        send(32'h0BAD_F00D, 1'b1, 4, -1, "R6 new width after boundary");
        send(32'h7E57_1234, 1'b0, 1, 3, "R6 chained change");
        send(32'h3C3C_C3C3, 1'b0, 3, -1, "R7 after change");
        idle(25);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule